// File: doc/BRIEF.md
# Flash Chip Window Segment Decoder

This block maps a bus address onto one of several flash chip selects. Every chip owns one window register. The register gives the first and the last-plus-one boundary of the chip's address window, both counted in coarse 8 MB units. An incoming lookup request carries an address. The reply reports whether any window claims that address, which chip select claims it, and the byte offset of the address inside that chip's window.

Software programs the windows through a plain register port. The storage checks every write before it takes effect. A write is dropped, and the old contents remain, when it describes an open window that reaches outside the configured span or that collides with a window of a lower-numbered chip. Software confirms acceptance by reading the register back. A window whose first boundary is not below its end boundary counts as closed, and it never claims an address.

Lookups travel on a valid/ready request channel and a valid/ready response channel, with a one-entry response register between them. A request is taken whenever the response register is empty or is being drained in the same cycle. A reply waiting with `rsp_ready` low holds all its fields unchanged.

Top module: `flash_seg_decoder`

## Requirements
- R1: After reset the windows lie back to back from unit 0x40. Chip 0 covers 8 units and each later chip covers 4 units, so the readback values are 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000 for chips 0 to 4.
- R2: Chip i's window register is at byte offset 0x30 + 4*i. Bits [31:24] hold the end unit, bits [23:16] hold the first unit, and bits [15:0] always read as zero. Any other offset, including unaligned offsets and offsets past the last chip, reads as zero, and a write to such an offset changes nothing.
- R3: An address whose bits [30:23] lie at or above a window's first unit and below its end unit hits that window. The reply gives that chip's index and the offset, which is the address minus (first unit << 23).
- R4: A window whose first unit is greater than or equal to its end unit is closed and produces no hit. A write that closes a window is always accepted.
- R5: When no window claims the address, the reply has hit = 0, chip index 0 and offset 0.
- R6: When several windows claim the address, the lowest chip index wins.
- R7: A write describing an open window is rejected if its first unit is below 0x40 or its end unit is above 0x60, which is the base plus a span of 32 units.
- R8: A write describing an open window is rejected if it overlaps an open window of any lower-numbered chip. A rejected write leaves the previous value readable. Overlaps with higher-numbered chips are not checked.
- R9: `req_ready` is high when the response register is empty or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the reply fields stay stable.
- R10: A lookup uses the window contents in force during the cycle in which the request is accepted. A register write in that same cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 31 | Bus address to decode |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Consumer takes the reply |
| rsp_hit | output | 1 | Some open window claims the address |
| rsp_cs | output | 3 | Winning chip-select index |
| rsp_offset | output | 31 | Address offset inside the winning window |

## Verification
Overlapping open windows are the hardest case to reach, because the write check refuses any window that collides with a lower chip. The stimulus reaches overlap by rewriting chip 0 so that it swallows chip 1's window, since the check never looks upward, and then probes an address inside both windows. The second hard case is a register write landing in the same cycle as an accepted request. The bench issues both in one cycle and holds the reply with `rsp_ready` low to show that the older window contents were used.

// File: rtl/flash_seg_pkg.sv
package flash_seg_pkg;
  localparam int SEG_UNIT_W = 8;

  // Field order matches the register image bits [31:16]
  typedef struct packed {
    logic [SEG_UNIT_W-1:0] stop;
    logic [SEG_UNIT_W-1:0] first;
  } seg_win_t;
endpackage

// File: rtl/seg_window_regs.sv
module seg_window_regs
  import flash_seg_pkg::*;
#(
  parameter int                    NUM_CS      = 5,
  parameter int                    REG_AW      = 8,
  parameter logic [REG_AW-1:0]     REG_BASE    = 8'h30,
  parameter logic [SEG_UNIT_W-1:0] BASE_UNIT   = 8'h40,
  parameter int                    SPAN_UNITS  = 32,
  parameter int                    FIRST_UNITS = 8,
  parameter int                    NEXT_UNITS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output seg_win_t          win_q [NUM_CS]
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [REG_AW-1:0] MAP_BYTES = REG_AW'(4 * NUM_CS);
  localparam logic [SEG_UNIT_W:0] LIMIT_U =
    (SEG_UNIT_W+1)'(int'(BASE_UNIT) + SPAN_UNITS);

  logic [REG_AW-1:0] rel;
  logic              in_map;
  logic [CS_W-1:0]   sel;
  seg_win_t          cand;
  logic              cand_open;
  logic              cand_ok;
  logic              unused_low;

  assign rel    = reg_addr - REG_BASE;
  assign in_map = (reg_addr >= REG_BASE) && (rel < MAP_BYTES) && (rel[1:0] == 2'b00);
  assign sel    = CS_W'(rel >> 2);

  assign cand       = reg_wdata[31:16];
  assign cand_open  = cand.first < cand.stop;
  assign unused_low = ^reg_wdata[15:0];

  // Legality of an incoming window: span limits, then downward overlap scan
  always_comb begin
    cand_ok = 1'b1;
    if (cand_open) begin
      if (cand.first < BASE_UNIT) cand_ok = 1'b0;
      if ({1'b0, cand.stop} > LIMIT_U) cand_ok = 1'b0;
      for (int j = 0; j < NUM_CS; j++) begin
        if ((CS_W'(j) < sel) &&
            (win_q[j].first < win_q[j].stop) &&
            (cand.first < win_q[j].stop) &&
            (win_q[j].first < cand.stop))
          cand_ok = 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    localparam int OFS = (i == 0) ? 0 : FIRST_UNITS + (i - 1) * NEXT_UNITS;
    localparam int SZ  = (i == 0) ? FIRST_UNITS : NEXT_UNITS;
    localparam seg_win_t DFLT = '{
      stop:  SEG_UNIT_W'(int'(BASE_UNIT) + OFS + SZ),
      first: SEG_UNIT_W'(int'(BASE_UNIT) + OFS)
    };

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[i] <= DFLT;
      end else if (reg_wr && in_map && (sel == CS_W'(i)) && cand_ok) begin
        win_q[i] <= cand;
      end
    end
  end

  assign reg_rdata = in_map ? {win_q[sel], 16'h0000} : 32'h0;
endmodule

// File: rtl/seg_range_match.sv
module seg_range_match
  import flash_seg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic [SEG_UNIT_W-1:0] unit,
  input  seg_win_t              win [NUM_CS],
  output logic [NUM_CS-1:0]     hit_vec
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    logic is_open;
    assign is_open    = win[i].first < win[i].stop;
    assign hit_vec[i] = is_open && (unit >= win[i].first) && (unit < win[i].stop);
  end
endmodule

// File: rtl/seg_first_hit.sv
module seg_first_hit #(
  parameter int NUM_CS = 5,
  parameter int CS_W   = 3
) (
  input  logic [NUM_CS-1:0] hit_vec,
  output logic              any_hit,
  output logic [CS_W-1:0]   pick
);
  // Scan downward so the lowest set index is the last one written
  always_comb begin
    any_hit = 1'b0;
    pick    = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        pick    = CS_W'(i);
      end
    end
  end
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import flash_seg_pkg::*;
#(
  parameter int                    NUM_CS      = 5,
  parameter int                    UNIT_SHIFT  = 23,
  parameter int                    REG_AW      = 8,
  parameter logic [REG_AW-1:0]     REG_BASE    = 8'h30,
  parameter logic [SEG_UNIT_W-1:0] BASE_UNIT   = 8'h40,
  parameter int                    SPAN_UNITS  = 32,
  parameter int                    FIRST_UNITS = 8,
  parameter int                    NEXT_UNITS  = 4,
  localparam int                   ADDR_W      = SEG_UNIT_W + UNIT_SHIFT,
  localparam int                   CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [CS_W-1:0]   rsp_cs,
  output logic [ADDR_W-1:0] rsp_offset
);
  seg_win_t                win [NUM_CS];
  logic [NUM_CS-1:0]       hit_vec;
  logic                    any_hit;
  logic [CS_W-1:0]         pick;
  logic [SEG_UNIT_W-1:0]   req_unit;
  logic [ADDR_W-1:0]       win_base;
  logic [ADDR_W-1:0]       calc_offset;
  logic                    req_fire;

  seg_window_regs #(
    .NUM_CS(NUM_CS), .REG_AW(REG_AW), .REG_BASE(REG_BASE), .BASE_UNIT(BASE_UNIT),
    .SPAN_UNITS(SPAN_UNITS), .FIRST_UNITS(FIRST_UNITS), .NEXT_UNITS(NEXT_UNITS)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_q(win)
  );

  assign req_unit = req_addr[ADDR_W-1:UNIT_SHIFT];

  seg_range_match #(.NUM_CS(NUM_CS)) i_match (
    .unit(req_unit), .win(win), .hit_vec(hit_vec)
  );

  seg_first_hit #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_pick (
    .hit_vec(hit_vec), .any_hit(any_hit), .pick(pick)
  );

  assign win_base    = {win[pick].first, {UNIT_SHIFT{1'b0}}};
  assign calc_offset = any_hit ? (req_addr - win_base) : '0;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_cs     <= '0;
      rsp_offset <= '0;
    end else if (req_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= any_hit;
      rsp_cs     <= any_hit ? pick : '0;
      rsp_offset <= calc_offset;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_seg_decoder_chk.sv
module flash_seg_decoder_chk
  import flash_seg_pkg::*;
#(
  parameter int                    NUM_CS     = 5,
  parameter int                    UNIT_SHIFT = 23,
  parameter logic [SEG_UNIT_W-1:0] BASE_UNIT  = 8'h40,
  parameter int                    SPAN_UNITS = 32,
  localparam int                   ADDR_W     = SEG_UNIT_W + UNIT_SHIFT,
  localparam int                   CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [CS_W-1:0]   rsp_cs,
  input logic [ADDR_W-1:0] rsp_offset,
  input seg_win_t          win [NUM_CS]
);
  localparam logic [SEG_UNIT_W:0] LIMIT_U =
    (SEG_UNIT_W+1)'(int'(BASE_UNIT) + SPAN_UNITS);
  localparam logic [ADDR_W:0] SPAN_BYTES = (ADDR_W+1)'(SPAN_UNITS) << UNIT_SHIFT;

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_cs == '0 && rsp_offset == '0));

  assert_cs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (int'(rsp_cs) < NUM_CS));

  assert_offset_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ({1'b0, rsp_offset} < SPAN_BYTES));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_hit) && $stable(rsp_cs) && $stable(rsp_offset)));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_lim
    assert_win_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win[i].first < win[i].stop) |->
        (win[i].first >= BASE_UNIT && {1'b0, win[i].stop} <= LIMIT_U));
  end
endmodule

bind flash_seg_decoder flash_seg_decoder_chk #(
  .NUM_CS(NUM_CS), .UNIT_SHIFT(UNIT_SHIFT), .BASE_UNIT(BASE_UNIT), .SPAN_UNITS(SPAN_UNITS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_cs(rsp_cs), .rsp_offset(rsp_offset), .win(win)
);

// File: tb/test_flash_seg_decoder.sv
`timescale 1ns/1ps
module test_flash_seg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [30:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [2:0]  rsp_cs;
  logic [30:0] rsp_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_seg_decoder i_flash_seg_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_cs(rsp_cs), .rsp_offset(rsp_offset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic lookup(input string tag, input logic [30:0] a, input logic hit,
                        input logic [2:0] cs, input logic [30:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " hit"}, {31'b0, rsp_hit}, {31'b0, hit});
    chk({tag, " cs"}, {29'b0, rsp_cs}, {29'b0, cs});
    chk({tag, " offset"}, {1'b0, rsp_offset}, {1'b0, off});
  endtask

  // R1: contiguous default windows
  task automatic t_reset_defaults();
    logic [31:0] v;
    logic [31:0] exp [5] = '{32'h48400000, 32'h4C480000, 32'h504C0000,
                             32'h54500000, 32'h58540000};
    do_reset();
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);
    for (int i = 0; i < 5; i++) begin
      reg_read(8'(8'h30 + 4 * i), v);
      chk($sformatf("R1 default cs%0d", i), v, exp[i]);
    end
  endtask

  // R3 and R5: decode against the default map
  task automatic t_default_lookup();
    do_reset();
    lookup("R3 cs0 inner", 31'h2100_0010, 1'b1, 3'd0, 31'h0100_0010);
    lookup("R3 cs1 first byte", 31'h2400_0000, 1'b1, 3'd1, 31'h0);
    lookup("R3 cs1 last word", 31'h25FF_FFFC, 1'b1, 3'd1, 31'h01FF_FFFC);
    lookup("R3 cs4 top unit", 31'h2B80_0000, 1'b1, 3'd4, 31'h0180_0000);
    lookup("R5 above last end", 31'h2C00_0000, 1'b0, 3'd0, 31'h0);
    lookup("R5 below base", 31'h1000_0004, 1'b0, 3'd0, 31'h0);
  endtask

  // R2: field layout and ignored offsets
  task automatic t_reg_map();
    logic [31:0] v;
    do_reset();
    reg_write(8'h30, 32'h4840_1234);
    reg_read(8'h30, v);
    chk("R2 low half reads zero", v, 32'h48400000);
    reg_write(8'h44, 32'h5048_0000);
    reg_read(8'h44, v);
    chk("R2 offset past last chip", v, 32'h0);
    reg_write(8'h32, 32'h4440_0000);
    reg_read(8'h30, v);
    chk("R2 unaligned write ignored", v, 32'h48400000);
    reg_read(8'h2C, v);
    chk("R2 offset below map", v, 32'h0);
  endtask

  // R4: closed windows accepted and never hit
  task automatic t_closed();
    logic [31:0] v;
    do_reset();
    reg_write(8'h38, 32'h4C4C_0000);
    reg_read(8'h38, v);
    chk("R4 equal bounds accepted", v, 32'h4C4C0000);
    lookup("R4 equal bounds no hit", 31'h2600_0000, 1'b0, 3'd0, 31'h0);
    reg_write(8'h38, 32'h4C50_0000);
    reg_read(8'h38, v);
    chk("R4 inverted bounds accepted", v, 32'h4C500000);
    lookup("R4 inverted bounds no hit", 31'h2600_0000, 1'b0, 3'd0, 31'h0);
  endtask

  // R7: span limits
  task automatic t_limits();
    logic [31:0] v;
    do_reset();
    reg_write(8'h3C, 32'h6158_0000);
    reg_read(8'h3C, v);
    chk("R7 end past limit rejected", v, 32'h54500000);
    reg_write(8'h3C, 32'h6058_0000);
    reg_read(8'h3C, v);
    chk("R7 end at limit accepted", v, 32'h60580000);
    reg_write(8'h30, 32'h4038_0000);
    reg_read(8'h30, v);
    chk("R7 start below base rejected", v, 32'h48400000);
  endtask

  // R8 and R6: downward overlap check, lowest index priority
  task automatic t_overlap();
    logic [31:0] v;
    do_reset();
    reg_write(8'h34, 32'h4A46_0000);
    reg_read(8'h34, v);
    chk("R8 overlap with cs0 rejected", v, 32'h4C480000);
    reg_write(8'h34, 32'h4A48_0000);
    reg_read(8'h34, v);
    chk("R8 adjacent window accepted", v, 32'h4A480000);
    reg_write(8'h30, 32'h5040_0000);
    reg_read(8'h30, v);
    chk("R8 upward overlap accepted", v, 32'h50400000);
    lookup("R6 lowest index wins", 31'h2480_0000, 1'b1, 3'd0, 31'h0480_0000);
  endtask

  // R9 and R10: stall, hold, same-cycle write
  task automatic t_stall();
    do_reset();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 31'h2100_0010; rsp_ready = 1'b0;
    reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h4040_0000;
    @(negedge clk);
    reg_wr = 1'b0;
    req_addr = 31'h2100_0000;
    chk("R9 req_ready low while stalled", {31'b0, req_ready}, 32'd0);
    chk("R10 old window used hit", {31'b0, rsp_hit}, 32'd1);
    chk("R10 old window used offset", {1'b0, rsp_offset}, 32'h0100_0010);
    @(negedge clk);
    chk("R9 reply held valid", {31'b0, rsp_valid}, 32'd1);
    chk("R9 reply held offset", {1'b0, rsp_offset}, 32'h0100_0010);
    rsp_ready = 1'b1;
    #1;
    chk("R9 req_ready follows rsp_ready", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 closed cs0 now misses", {31'b0, rsp_hit}, 32'd0);
    chk("R9 second reply valid", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R9 reply drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    t_reset_defaults();
    t_default_lookup();
    t_reg_map();
    t_closed();
    t_limits();
    t_overlap();
    t_stall();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule